// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder

This block adds two 64-bit operands as a set of independent lanes. A run-time size control splits the operands into eight 8-bit lanes or four 16-bit lanes. Each lane adds its own pair of fields, and no carry crosses the edge between two lanes. Inside a 16-bit lane the carry still ripples from the low byte into the high byte.

Two run-time options shape the result. With saturation on, a lane whose unsigned sum overflows is clamped to all ones. With carry capture on and saturation off, the result holds the wrapped sums. A second output word then holds each lane's carry-out in the lowest bit of that lane. When both options are set, saturation takes priority. The operation is issued with a valid strobe. Its result appears on registered outputs one cycle later, and there is no backpressure.

Top module: `simd_sat_add`

## Requirements
- R1: With `lane_wide`=0 and both options off, each byte of `sum_out` equals (byte of `op_a` + byte of `op_b`) mod 256.
- R2: With `lane_wide`=1 and both options off, each 16-bit lane of `sum_out` equals the lane sum mod 65536, with the carry from bit 7 rippling into bit 8 of the lane.
- R3: A carry out of a lane's top bit (bit 7 of a byte lane, bit 15 of a 16-bit lane) never changes any other lane of `sum_out` or `carry_out`.
- R4: With `sat_en`=1, a lane whose unsigned sum overflows reads all ones, and every other lane holds its exact sum.
- R5: With `cst_en`=1 and `sat_en`=0, `sum_out` holds the wrapped lane sums. Each lane of `carry_out` holds that lane's carry-out in its bit 0 and zeros in all its other bits.
- R6: When `sat_en` and `cst_en` are both 1, the saturated result is produced and `carry_out` is all zeros.
- R7: When `cst_en`=0, `carry_out` is all zeros.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `sum_out` and `carry_out` keep their values through any cycle whose `in_valid` is low.
- R9: A synchronous active-high `rst` clears `sum_out`, `carry_out` and `out_valid` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| lane_wide | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| sat_en | input | 1 | Unsigned saturation enable |
| cst_en | input | 1 | Carry capture enable |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| sum_out | output | 64 | Lane results |
| carry_out | output | 64 | Per-lane carry word |

## Verification
A faulty carry cut or carry gate would show in the very next result. A single carry placed at a boundary changes the neighbouring lane by one, so each boundary gets its own directed case. A wrong lane-carry choice in 16-bit mode would show as a clamped or captured low byte whose lane did not overflow. A fault in the output register or the valid pipeline would show as a change in held data, or as `out_valid` out of step with the strobe one cycle earlier.

// File: rtl/simd_sat_add_pkg.sv
package simd_sat_add_pkg;

  typedef enum logic [1:0] {
    FIX_WRAP = 2'd0,
    FIX_SAT  = 2'd1,
    FIX_CST  = 2'd2
  } fix_mode_t;

  // saturation wins over carry capture
  function automatic fix_mode_t pick_mode(input logic sat, input logic cst);
    if (sat)      return FIX_SAT;
    else if (cst) return FIX_CST;
    else          return FIX_WRAP;
  endfunction

endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             cout
);
  localparam int TOP = SEG_W - 1;

  always_comb begin
    sum  = a + b + {{(SEG_W-1){1'b0}}, cin};
    // carry out of the top bit, rebuilt from operands and sum
    cout = (a[TOP] & b[TOP]) | ((a[TOP] ^ b[TOP]) & ~sum[TOP]);
  end
endmodule

// File: rtl/simd_lane_join.sv
module simd_lane_join #(
  parameter int NSEG = 8
) (
  input  logic            lane_wide,
  input  logic [NSEG-1:0] seg_cout,
  output logic [NSEG-1:0] seg_cin,
  output logic [NSEG-1:0] lane_carry
);
  for (genvar i = 0; i < NSEG; i++) begin : g_join
    if (i % 2 == 1) begin : g_hi
      assign seg_cin[i]    = lane_wide & seg_cout[i-1];
      assign lane_carry[i] = seg_cout[i];
    end else begin : g_lo
      assign seg_cin[i]    = 1'b0;
      assign lane_carry[i] = lane_wide ? seg_cout[i+1] : seg_cout[i];
    end
  end
endmodule

// File: rtl/simd_seg_fix.sv
module simd_seg_fix
  import simd_sat_add_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter bit SEG_HI = 1'b0
) (
  input  fix_mode_t        mode,
  input  logic             lane_wide,
  input  logic [SEG_W-1:0] raw_sum,
  input  logic             lane_carry,
  output logic [SEG_W-1:0] fixed_sum,
  output logic [SEG_W-1:0] carry_seg
);
  logic own_bit;

  // in 16-bit lanes only the low segment carries the flag bit
  assign own_bit = SEG_HI ? ~lane_wide : 1'b1;

  always_comb begin
    fixed_sum = raw_sum;
    carry_seg = '0;
    unique case (mode)
      FIX_SAT: fixed_sum = raw_sum | {SEG_W{lane_carry}};
      FIX_CST: carry_seg[0] = lane_carry & own_bit;
      default: ;
    endcase
  end
endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
  import simd_sat_add_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              lane_wide,
  input  logic              sat_en,
  input  logic              cst_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum_out,
  output logic [DATA_W-1:0] carry_out
);
  localparam int NSEG = DATA_W / SEG_W;

  fix_mode_t         mode;
  logic [NSEG-1:0]   seg_cout, seg_cin, lane_carry;
  logic [DATA_W-1:0] raw_sum, fixed_sum, carry_word;

  assign mode = pick_mode(sat_en, cst_en);

  simd_lane_join #(.NSEG(NSEG)) u_join (
    .lane_wide  (lane_wide),
    .seg_cout   (seg_cout),
    .seg_cin    (seg_cin),
    .lane_carry (lane_carry)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    simd_seg_add #(.SEG_W(SEG_W)) u_add (
      .a    (op_a[i*SEG_W +: SEG_W]),
      .b    (op_b[i*SEG_W +: SEG_W]),
      .cin  (seg_cin[i]),
      .sum  (raw_sum[i*SEG_W +: SEG_W]),
      .cout (seg_cout[i])
    );
    simd_seg_fix #(.SEG_W(SEG_W), .SEG_HI(i % 2 == 1)) u_fix (
      .mode       (mode),
      .lane_wide  (lane_wide),
      .raw_sum    (raw_sum[i*SEG_W +: SEG_W]),
      .lane_carry (lane_carry[i]),
      .fixed_sum  (fixed_sum[i*SEG_W +: SEG_W]),
      .carry_seg  (carry_word[i*SEG_W +: SEG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum_out   <= '0;
      carry_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_out   <= fixed_sum;
        carry_out <= carry_word;
      end
    end
  end
endmodule

// File: rtl/simd_sat_add_chk.sv
module simd_sat_add_chk #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic              lane_wide,
  input logic              sat_en,
  input logic              cst_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] sum_out,
  input logic [DATA_W-1:0] carry_out
);
  localparam int NSEG = DATA_W / SEG_W;

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum_out) && $stable(carry_out)));
  // R7
  no_carry_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cst_en) |=> (carry_out == '0));
  // R6
  sat_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en && cst_en) |=> (carry_out == '0));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && sum_out == '0 && carry_out == '0));

  for (genvar i = 0; i < NSEG; i++) begin : g_lane_chk
    // R4
    sat_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sat_en && !lane_wide) |=>
        (sum_out[i*SEG_W +: SEG_W] >= $past(op_a[i*SEG_W +: SEG_W])));
    // R5
    carry_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cst_en && !sat_en) |=>
        (carry_out[i*SEG_W+1 +: SEG_W-1] == '0));
    if (i % 2 == 1) begin : g_hi
      // R5
      wide_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cst_en && lane_wide) |=> (carry_out[i*SEG_W] == 1'b0));
    end
  end
endmodule

bind simd_sat_add simd_sat_add_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .lane_wide (lane_wide),
  .sat_en    (sat_en),
  .cst_en    (cst_en),
  .out_valid (out_valid),
  .sum_out   (sum_out),
  .carry_out (carry_out)
);

// File: tb/tb_simd_sat_add.sv
module tb_simd_sat_add;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic        lane_wide, sat_en, cst_en;
  logic        out_valid;
  logic [63:0] sum_out, carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_sat_add dut (
    .clk (clk), .rst (rst), .in_valid (in_valid),
    .op_a (op_a), .op_b (op_b), .lane_wide (lane_wide),
    .sat_en (sat_en), .cst_en (cst_en), .out_valid (out_valid),
    .sum_out (sum_out), .carry_out (carry_out)
  );

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic w, input logic s, input logic c,
                                output logic [63:0] rs, output logic [63:0] rc);
    int lw = w ? 16 : 8;
    rs = '0;
    rc = '0;
    for (int i = 0; i < 64 / lw; i++) begin
      logic [16:0] x, y, t;
      logic        co;
      x  = 17'((a >> (i*lw)) & ((64'd1 << lw) - 1));
      y  = 17'((b >> (i*lw)) & ((64'd1 << lw) - 1));
      t  = x + y;
      co = t[lw];
      t  = t & 17'((1 << lw) - 1);
      if (s && co) t = 17'((1 << lw) - 1);
      rs = rs | (64'(t) << (i*lw));
      if (c && !s) rc = rc | (64'(co) << (i*lw));
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic w, input logic s, input logic c);
    logic [63:0] es, ec;
    string ts, tc;
    model(a, b, w, s, c, es, ec);
    ts = s ? "R4" : (c ? "R5" : (w ? "R2" : "R1"));
    tc = (s && c) ? "R6" : (c ? "R5" : "R7");
    @(negedge clk);
    op_a = a; op_b = b; lane_wide = w; sat_en = s; cst_en = c; in_valid = 1'b1;
    @(posedge clk); #2;
    check({tag, " ", ts, " sum"}, sum_out, es);
    check({tag, " ", tc, " carry"}, carry_out, ec);
    check({tag, " R8 valid"}, 64'(out_valid), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] hs, hc;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
    lane_wide = 1'b0; sat_en = 1'b0; cst_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset sum", sum_out, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // all ones, both sizes, every flag combination
    for (int k = 0; k < 8; k++)
      run_op("ones", '1, '1, k[2], k[1], k[0]);

    // R3: one carry at each lane boundary, both sizes
    for (int i = 0; i < 8; i++) begin
      run_op("R3 byte edge", 64'h80 << (8*i), 64'h80 << (8*i), 1'b0, 1'b0, 1'b0);
      run_op("R3 byte edge cst", 64'hFF << (8*i), 64'h01 << (8*i), 1'b0, 1'b0, 1'b1);
    end
    for (int i = 0; i < 4; i++) begin
      run_op("R3 word edge", 64'h8000 << (16*i), 64'h8000 << (16*i), 1'b1, 1'b0, 1'b1);
      run_op("R2 inner ripple", 64'h00FF << (16*i), 64'h0001 << (16*i), 1'b1, 1'b1, 1'b0);
    end

    // random traffic with every flag combination
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      run_op("rand", ra, rb, n[0], n[1], n[2]);
    end

    // R8: idle strobe keeps outputs, new operands ignored
    run_op("pre-hold", 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b0, 1'b1);
    hs = sum_out; hc = carry_out;
    @(negedge clk);
    op_a = '1; op_b = '1; sat_en = 1'b1; in_valid = 1'b0;
    @(posedge clk); #2;
    check("R8 idle valid", 64'(out_valid), 64'd0);
    check("R8 hold sum", sum_out, hs);
    check("R8 hold carry", carry_out, hc);

    // R9: reset in mid-run
    run_op("pre-reset", '1, 64'd1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #2;
    check("R9 mid valid", 64'(out_valid), 64'd0);
    check("R9 mid sum", sum_out, 64'd0);
    check("R9 mid carry", carry_out, 64'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule